// File: doc/BRIEF.md
# Unaligned Multi-Lane Window Fetch

This block lets a row of parallel evaluation kernels read a run of adjacent integral-image words in one access, wherever that run starts. Kernel k always gets the word k positions to the right of the word asked for on behalf of kernel 0. The run need not start on a chunk boundary. A single memory port can only return one aligned chunk, so the block keeps two identical copies of the word store. One copy is read at the requested chunk and the other at the chunk that follows it. A selector then cuts the requested run out of the 32 words that come back.

The read address is split in two. The high part names the chunk and the low part gives the starting word within the two-chunk span. Data is loaded one whole chunk at a time, and each load goes into both copies on the same edge, so the copies never differ. Word width is a parameter: 21 bits suits a plain integral image and 29 bits a squared one. With default parameters there are 16 lanes and a 13-bit read address.

Top module: `win_router`

## Requirements
- R1: After a read at address A, with c = A[12:4] and p = A[3:0], lane k of `rd_words` (bits k*WORD_W upward) holds word p+k of the 32-word span made of chunk c (words 0..15) followed by chunk c+1 (words 16..31).
- R2: The chunk index is taken from the upper 9 address bits and the start offset from the lower 4. For example, p = 3 puts words 3 through 18 of the span on lanes 0 through 15.
- R3: Read data and `rd_valid` appear one clock edge after the edge that samples `rd_en` high.
- R4: While reset is asserted, and on the first edge after it, `rd_valid` is 0.
- R5: An edge that samples `rd_en` low drives `rd_valid` low and leaves `rd_words` unchanged, even if a chunk is written meanwhile.
- R6: An edge that samples `wr_en` high stores `wr_data` at chunk `wr_chunk` in both copies, with word j at bits j*WORD_W. Reads on later edges return the new data.
- R7: A read on the same edge as a write to a chunk it covers returns that chunk's contents from before the write.
- R8: With offset 0, lanes 0..15 carry chunk c exactly. With offset 15, lane 0 carries word 15 of chunk c and lanes 1..15 carry words 0..14 of chunk c+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Start a window read |
| rd_addr | input | 13 | Chunk index (upper 9 bits) and start offset (lower 4 bits) |
| wr_en | input | 1 | Write one chunk into both copies |
| wr_chunk | input | 9 | Chunk index for the write |
| wr_data | input | 336 | Sixteen words, word j at bits j*21 |
| rd_valid | output | 1 | `rd_words` holds the result of the previous edge's read |
| rd_words | output | 336 | Sixteen words, lane k at bits k*21 |

## Verification
The case that is hardest to reach from the ports is a read issued on the same edge that rewrites one of the two chunks it covers, with the window also straddling the chunk boundary. The returned words then come from stale data in two different copies at once. Directed sequences set up exactly that collision at a nonzero offset, and then read again to confirm the new data. Randomised reads mixed with writes, plus bursts of consecutive addresses that keep `rd_en` high, cover every offset and the carry from one chunk into the next.

// File: rtl/win_router_pkg.sv
package win_router_pkg;
    localparam int DEF_WORD_W   = 21;
    localparam int DEF_LANES    = 16;
    localparam int DEF_CHUNK_AW = 9;
endpackage

// File: rtl/win_chunk_ram.sv
module win_chunk_ram #(
    parameter int DATA_W = 336,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [0:DEPTH-1];

    // Read-first: a read on a write edge sees the old line.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/win_span_mux.sv
module win_span_mux #(
    parameter int WORD_W = 21,
    parameter int LANES  = 16,
    parameter int SEL_W  = 4
) (
    input  logic [LANES*WORD_W-1:0] lo_line,
    input  logic [LANES*WORD_W-1:0] hi_line,
    input  logic [SEL_W-1:0]        sel,
    output logic [LANES*WORD_W-1:0] win
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [SEL_W:0] idx;
        always_comb begin
            idx = {1'b0, sel} + (SEL_W+1)'(k);
            if (idx[SEL_W]) begin
                win[k*WORD_W +: WORD_W] = hi_line[int'(idx[SEL_W-1:0])*WORD_W +: WORD_W];
            end else begin
                win[k*WORD_W +: WORD_W] = lo_line[int'(idx[SEL_W-1:0])*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/win_router.sv
module win_router #(
    parameter int WORD_W   = win_router_pkg::DEF_WORD_W,
    parameter int LANES    = win_router_pkg::DEF_LANES,
    parameter int CHUNK_AW = win_router_pkg::DEF_CHUNK_AW,
    localparam int SEL_W   = $clog2(LANES),
    localparam int ADDR_W  = CHUNK_AW + SEL_W,
    localparam int LINE_W  = LANES * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                wr_en,
    input  logic [CHUNK_AW-1:0] wr_chunk,
    input  logic [LINE_W-1:0]   wr_data,
    output logic                rd_valid,
    output logic [LINE_W-1:0]   rd_words
);
    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] sel;
    } rd_state_t;

    rd_state_t state_d, state_q;

    logic [CHUNK_AW-1:0] copy_raddr [2];
    logic [LINE_W-1:0]   copy_rdata [2];

    // Lower copy reads the addressed chunk; upper copy the next one (wraps).
    assign copy_raddr[0] = rd_addr[ADDR_W-1:SEL_W];
    assign copy_raddr[1] = rd_addr[ADDR_W-1:SEL_W] + CHUNK_AW'(1);

    for (genvar g = 0; g < 2; g++) begin : g_copy
        win_chunk_ram #(
            .DATA_W(LINE_W),
            .ADDR_W(CHUNK_AW)
        ) u_ram (
            .clk  (clk),
            .we   (wr_en),
            .waddr(wr_chunk),
            .wdata(wr_data),
            .re   (rd_en),
            .raddr(copy_raddr[g]),
            .rdata(copy_rdata[g])
        );
    end

    // Offset travels with the read so the mux matches the returned lines.
    always_comb begin
        state_d       = state_q;
        state_d.valid = rd_en;
        if (rd_en) begin
            state_d.sel = rd_addr[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    win_span_mux #(
        .WORD_W(WORD_W),
        .LANES (LANES),
        .SEL_W (SEL_W)
    ) u_mux (
        .lo_line(copy_rdata[0]),
        .hi_line(copy_rdata[1]),
        .sel    (state_q.sel),
        .win    (rd_words)
    );

    assign rd_valid = state_q.valid;
endmodule

// File: rtl/win_router_chk.sv
module win_router_chk #(
    parameter int WORD_W = 21,
    parameter int LANES  = 16,
    parameter int ADDR_W = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rd_en,
    input logic [ADDR_W-1:0]       rd_addr,
    input logic                    wr_en,
    input logic                    rd_valid,
    input logic [LANES*WORD_W-1:0] rd_words
);
    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (rd_en) begin
            seen_q <= 1'b1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !rd_valid); // R4

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !rd_en) |=> (!rd_valid && $stable(rd_words))); // R5

    AST_WINDOW_SLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && !$past(wr_en) && rd_addr != '0 &&
         rd_addr == $past(rd_addr) + ADDR_W'(1))
        |=> rd_words[(LANES-1)*WORD_W-1:0] == $past(rd_words[LANES*WORD_W-1:WORD_W])); // R1

    AST_REPEAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && !$past(wr_en) && rd_addr == $past(rd_addr))
        |=> $stable(rd_words)); // R2
endmodule

bind win_router win_router_chk #(
    .WORD_W(WORD_W),
    .LANES (LANES),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .rd_valid(rd_valid),
    .rd_words(rd_words)
);

// File: tb/win_router_tb.sv
`timescale 1ns/1ps
module win_router_tb;
    localparam int W      = 21;
    localparam int LANES  = 16;
    localparam int CAW    = 9;
    localparam int AW     = 13;
    localparam int LINE_W = LANES * W;
    localparam int NCH    = 1 << CAW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic              wr_en = 1'b0;
    logic [CAW-1:0]    wr_chunk = '0;
    logic [LINE_W-1:0] wr_data = '0;
    logic              rd_valid;
    logic [LINE_W-1:0] rd_words;

    int errors = 0;
    int checks = 0;
    logic [LINE_W-1:0] model [0:NCH-1];

    always #2.5 clk = ~clk;

    win_router u_dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_chunk(wr_chunk), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_words(rd_words)
    );

    function automatic logic [LINE_W-1:0] rand_line();
        logic [LINE_W-1:0] l;
        for (int j = 0; j < LANES; j++) l[j*W +: W] = W'($urandom);
        return l;
    endfunction

    function automatic logic [LINE_W-1:0] expect_win(input logic [AW-1:0] a);
        logic [LINE_W-1:0] r;
        logic [CAW-1:0] c, cn;
        int p;
        c  = a[AW-1:4];
        cn = c + CAW'(1);
        p  = int'(a[3:0]);
        for (int k = 0; k < LANES; k++) begin
            if (p + k < LANES) r[k*W +: W] = model[c][(p+k)*W +: W];
            else               r[k*W +: W] = model[cn][(p+k-LANES)*W +: W];
        end
        return r;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [CAW-1:0] c, input logic [LINE_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_chunk = c; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[c] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input string req);
        logic [LINE_W-1:0] e;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        e = expect_win(a);
        @(negedge clk);
        rd_en = 1'b0;
        check(rd_words == e, req, rd_words, e);
        check(rd_valid == 1'b1, "R3", LINE_W'(rd_valid), LINE_W'(1));
    endtask

    task automatic burst(input logic [AW-1:0] a0, input int n);
        logic [LINE_W-1:0] e;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a0; e = expect_win(a0);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            check(rd_words == e, "R1", rd_words, e);
            if (i < n) begin
                rd_addr = a0 + AW'(i); e = expect_win(rd_addr);
            end else begin
                rd_en = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [LINE_W-1:0] hold, newl, e;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R4", LINE_W'(rd_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_valid == 1'b0, "R4", LINE_W'(rd_valid), '0);

        // R6: load every chunk in both copies
        for (int c = 0; c < NCH; c++) do_write(CAW'(c), rand_line());

        // R2: offset 3 gives words 3..18
        do_read({9'd7, 4'd3}, "R2");
        // R8: aligned and last-offset corners
        do_read({9'd20, 4'd0}, "R8");
        do_read({9'd20, 4'd15}, "R8");
        do_read({9'd511, 4'd0}, "R8");
        // R1: sliding bursts across a chunk boundary
        burst({9'd40, 4'd10}, 12);

        // R7: read colliding with a write to its upper chunk
        newl = rand_line();
        @(negedge clk);
        e = expect_win({9'd50, 4'd9});
        rd_en = 1'b1; rd_addr = {9'd50, 4'd9};
        wr_en = 1'b1; wr_chunk = 9'd51; wr_data = newl;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check(rd_words == e, "R7", rd_words, e);
        model[51] = newl;
        do_read({9'd50, 4'd9}, "R6");

        // R5: idle hold while writing to the viewed chunk
        do_read({9'd60, 4'd4}, "R1");
        hold = rd_words;
        do_write(9'd60, rand_line());
        @(negedge clk);
        check(rd_words == hold, "R5", rd_words, hold);
        check(rd_valid == 1'b0, "R5", LINE_W'(rd_valid), '0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(3) == 0) begin
                do_write(CAW'($urandom_range(NCH-1)), rand_line());
            end else begin
                logic [CAW-1:0] c;
                c = CAW'($urandom_range(NCH-2));
                do_read({c, 4'($urandom_range(15))}, "R1");
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule